// File: doc/BRIEF.md
# Rotating Unit-Element Selector for a Current-Steering DAC

This block sits between a multibit noise-shaping modulator and a bank of 32 matched current sources. For each modulator sample it decides which unit elements steer current. A plain thermometer decoder would always pick the lowest-numbered elements. This block instead keeps a start pointer that rotates. Each code turns on a contiguous run of elements that begins at the pointer and wraps past the last element back to element 0. The pointer then moves to the element just after the run. Over time every element is used about equally often, and the error from element mismatch is pushed out of band with first-order shaping.

A sample arrives as a level code qualified by a valid strobe. The block outputs the enable word and its bitwise complement from registers that load on the same clock edge, so both sides of each differential switch pair change together. When no sample is presented, the outputs and the pointer keep their values. Reset is synchronous and active-low.

Top module: `dwa_selector`

## Requirements
- R1: On a clock edge where `code_valid` is high, the enable word loads exactly N set bits. These are the N consecutive element positions starting at the current pointer, counted upward modulo 32. N is the code value, saturated at 32.
- R2: On each such edge the pointer advances by N modulo 32. The pointer does not move on edges where `code_valid` is low.
- R3: Code 0 loads an all-zero enable word and leaves the pointer unchanged. Code 32 loads all ones and also leaves the pointer unchanged. Any code above 32 on the 6-bit input behaves exactly like 32.
- R4: `elem_en_n` is always the bitwise inverse of `elem_en`. Both are registered and update on the edge that samples the code, so the new pattern is visible one cycle after the strobe.
- R5: While `code_valid` is low, both output words hold their previous values.
- R6: When `rst_n` is low at a clock edge, the enable word clears to zero, the complement word becomes all ones and the pointer returns to element 0. Reset takes priority over a valid code presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| code_valid | input | 1 | Qualifies `code` for this cycle |
| code | input | 6 | Number of elements to turn on (0 to 32, larger values saturate) |
| elem_en | output | 32 | Registered unit-element enables, bit i drives element i |
| elem_en_n | output | 32 | Registered bitwise complement of `elem_en` |

## Verification
Two functions can coincide in a single sample: the selected run wraps past element 31, and the pointer itself wraps to a smaller index. The bench sets this up on purpose. It first moves the pointer to 31 and then sends code 1. It then sends a run that straddles the boundary, followed by a full-scale code taken from a pointer other than zero. For each of these samples, the expected enable word comes from a modular-offset reference model, and the pointer position it implies is confirmed through where the next run starts. The same judgement is applied to a few hundred random codes with a random valid pattern, plus reset pulses inserted in the middle of the run.

// File: rtl/dwa_pkg.sv
// Package: shared constants for the rotating element selector.
// Assumes the element count is a power of two so that the pointer wraps
// by plain binary overflow.
package dwa_pkg;
    localparam int unsigned DWA_ELEMS_DEFAULT = 32;
endpackage

// File: rtl/dwa_ptr.sv
// Module: dwa_ptr
// Holds the rotation start pointer and advances it by the step on each
// accepted sample. Assumes ELEMS is a power of two: the addition wraps
// modulo ELEMS through truncation, so a full-scale step leaves it unchanged.
module dwa_ptr #(
    parameter int unsigned ELEMS  = dwa_pkg::DWA_ELEMS_DEFAULT,
    parameter int unsigned PTR_W  = $clog2(ELEMS),
    parameter int unsigned CODE_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_en,
    input  logic [CODE_W-1:0] step,
    output logic [PTR_W-1:0]  ptr
);
    logic [PTR_W-1:0] ptr_q;

    // Pointer register: clear on reset, otherwise add the step modulo ELEMS
    always_ff @(posedge clk) begin
        if (!rst_n)      ptr_q <= '0;
        else if (adv_en) ptr_q <= ptr_q + step[PTR_W-1:0];
    end

    assign ptr = ptr_q;

    // R2: an accepted sample moves the pointer by the step, modulo ELEMS
    assert_ptr_adv_R2: assert property (@(posedge clk) disable iff (!rst_n)
        adv_en |=> ptr_q == PTR_W'($past(ptr_q) + $past(step[PTR_W-1:0])));
    // R2: without a sample the pointer stays where it is
    assert_ptr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_en |=> $stable(ptr_q));
endmodule

// File: rtl/dwa_rotmask.sv
// Module: dwa_rotmask
// Combinational circular thermometer. Element i is selected when its
// distance above the pointer (modulo ELEMS) is less than the step. Assumes
// the step is already saturated at ELEMS.
module dwa_rotmask #(
    parameter int unsigned ELEMS  = dwa_pkg::DWA_ELEMS_DEFAULT,
    parameter int unsigned PTR_W  = $clog2(ELEMS),
    parameter int unsigned CODE_W = PTR_W + 1
) (
    input  logic [PTR_W-1:0]  ptr,
    input  logic [CODE_W-1:0] step,
    output logic [ELEMS-1:0]  mask
);
    // One comparator per element: modular offset from the pointer versus the run length
    for (genvar i = 0; i < ELEMS; i++) begin : g_elem
        logic [PTR_W-1:0] ofs;
        assign ofs     = PTR_W'(i) - ptr;
        assign mask[i] = ({1'b0, ofs} < step);
    end
endmodule

// File: rtl/dwa_outreg.sv
// Module: dwa_outreg
// Registers the true and complement enable words together, so that both
// sides of each differential switch change on the same edge. Holds the
// words while no sample is loaded.
module dwa_outreg #(
    parameter int unsigned ELEMS = dwa_pkg::DWA_ELEMS_DEFAULT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [ELEMS-1:0] mask,
    output logic [ELEMS-1:0] en,
    output logic [ELEMS-1:0] en_n
);
    logic [ELEMS-1:0] en_q;
    logic [ELEMS-1:0] en_n_q;

    // True-polarity register: all off after reset
    always_ff @(posedge clk) begin
        if (!rst_n)    en_q <= '0;
        else if (load) en_q <= mask;
    end

    // Complement-polarity register: all ones after reset
    always_ff @(posedge clk) begin
        if (!rst_n)    en_n_q <= '1;
        else if (load) en_n_q <= ~mask;
    end

    assign en   = en_q;
    assign en_n = en_n_q;

    // R4: the two registers always hold complementary words
    assert_compl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        en_n_q == ~en_q);
    // R5: with no sample, the outputs keep their values
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(en_q) && $stable(en_n_q)));
endmodule

// File: rtl/dwa_selector.sv
// Module: dwa_selector (top)
// Data-weighted-averaging selector. It saturates the incoming level code,
// builds a wrapping run of enables starting at the rotation pointer, and
// registers that run together with its complement. Assumes ELEMS is a
// power of two and that the code port is one bit wider than the pointer.
module dwa_selector #(
    parameter int unsigned ELEMS  = dwa_pkg::DWA_ELEMS_DEFAULT,
    parameter int unsigned PTR_W  = $clog2(ELEMS),
    parameter int unsigned CODE_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              code_valid,
    input  logic [CODE_W-1:0] code,
    output logic [ELEMS-1:0]  elem_en,
    output logic [ELEMS-1:0]  elem_en_n
);
    localparam logic [CODE_W-1:0] FULL = CODE_W'(ELEMS);

    logic [CODE_W-1:0] n_sat;
    logic [PTR_W-1:0]  ptr;
    logic [ELEMS-1:0]  mask;

    // Clamp codes above full scale to the element count
    always_comb begin
        n_sat = (code > FULL) ? FULL : code;
    end

    dwa_ptr #(.ELEMS(ELEMS), .PTR_W(PTR_W), .CODE_W(CODE_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .adv_en(code_valid), .step(n_sat), .ptr(ptr)
    );

    dwa_rotmask #(.ELEMS(ELEMS), .PTR_W(PTR_W), .CODE_W(CODE_W)) u_mask (
        .ptr(ptr), .step(n_sat), .mask(mask)
    );

    dwa_outreg #(.ELEMS(ELEMS)) u_out (
        .clk(clk), .rst_n(rst_n), .load(code_valid), .mask(mask),
        .en(elem_en), .en_n(elem_en_n)
    );

    // R1: the number of enabled elements equals the saturated code
    assert_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |=> $countones(elem_en) == int'($past(n_sat)));
    // R1: a non-empty run begins at the pointer held before the edge
    assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (code_valid && n_sat != '0) |=> elem_en[$past(ptr)]);
    // R3: a full-scale or larger code turns every element on
    assert_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (code_valid && code >= FULL) |=> (&elem_en));
    // R3: code zero turns every element off
    assert_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (code_valid && code == '0) |=> (elem_en == '0));
    // R6: reset clears the outputs and the pointer, even with a valid code present
    assert_reset_R6: assert property (@(posedge clk)
        !rst_n |=> (elem_en == '0 && elem_en_n == '1 && ptr == '0));
endmodule

// File: tb/dwa_selector_bench.sv
module dwa_selector_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        code_valid = 1'b0;
    logic [5:0]  code = '0;
    logic [31:0] elem_en;
    logic [31:0] elem_en_n;

    int checks = 0;
    int fails  = 0;
    logic [4:0]  m_ptr = '0;
    logic [31:0] m_en  = '0;

    always #4 clk = ~clk;

    dwa_selector u_dwa_selector (
        .clk(clk), .rst_n(rst_n), .code_valid(code_valid), .code(code),
        .elem_en(elem_en), .elem_en_n(elem_en_n)
    );

    // Reference: element i is on when (i - ptr) mod 32 is below the saturated count
    function automatic logic [31:0] exp_mask(input logic [4:0] p, input logic [5:0] c);
        int n = (c > 6'd32) ? 32 : int'(c);
        logic [31:0] r = '0;
        for (int i = 0; i < 32; i++) begin
            logic [4:0] ofs = 5'(i) - p;
            r[i] = (int'(ofs) < n);
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, update the model, check at the next falling edge
    task automatic cyc(input logic r, input logic v, input logic [5:0] c, input string req);
        rst_n = r; code_valid = v; code = c;
        if (!r) begin
            m_en = '0; m_ptr = '0;
        end else if (v) begin
            m_en  = exp_mask(m_ptr, c);
            m_ptr = m_ptr + 5'((c > 6'd32) ? 6'd32 : c);
        end
        @(negedge clk);
        check(req, elem_en, m_en);
        check("R4", elem_en_n, ~m_en);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        cyc(1'b0, 1'b1, 6'd7, "R6");              // reset wins over a valid code
        cyc(1'b0, 1'b0, 6'd0, "R6");
        cyc(1'b1, 1'b1, 6'd0,  "R3");             // code zero: nothing on, pointer stays
        cyc(1'b1, 1'b1, 6'd32, "R3");             // full scale: all on from pointer 0
        cyc(1'b1, 1'b1, 6'd5,  "R1");             // run 0..4 proves the pointer stayed at 0
        cyc(1'b1, 1'b0, 6'd9,  "R5");             // hold while invalid
        cyc(1'b1, 1'b1, 6'd26, "R2");             // pointer 5 -> 31
        cyc(1'b1, 1'b1, 6'd1,  "R2");             // run of one element at 31, pointer wraps to 0
        cyc(1'b1, 1'b1, 6'd3,  "R1");             // run starts at 0 again
        cyc(1'b1, 1'b1, 6'd27, "R2");             // pointer 3 -> 30
        cyc(1'b1, 1'b1, 6'd6,  "R1");             // wrapping run 30,31,0..3
        cyc(1'b1, 1'b1, 6'd32, "R3");             // full scale from pointer 4
        cyc(1'b1, 1'b1, 6'd63, "R3");             // above full scale saturates
        cyc(1'b1, 1'b1, 6'd2,  "R1");             // pointer still 4
        for (int k = 0; k < 400; k++) begin
            logic r = (($urandom % 97) != 0);
            logic v = (($urandom % 4) != 0);
            logic [5:0] c = 6'($urandom % 36);
            cyc(r, v, c, r ? (v ? "R1" : "R5") : "R6");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule